// File: doc/BRIEF.md
# JTAG Programming-Mode Entry Sequencer

This block is a host-side JTAG master. It drives TCK, TMS and TDI toward an attached target so that the target enters its serial programming mode. The host pulses `start` once. The sequencer first holds TMS high for a burst of TCK pulses, which forces the target's TAP controller into Test-Logic-Reset. It then walks the TAP to Select-DR-Scan and performs three 4-bit scans back to back: an instruction scan loading 0x2, a data scan loading 0x2, and a second instruction scan loading 0xC.

Between scans the TAP always leaves each Update state with TMS high, so it goes straight on to Select-DR-Scan and never passes through Run-Test/Idle. TCK comes from dividing the system clock. TMS and TDI change only on the falling edge of TCK. TDO is sampled on each rising edge that shifts a bit, and the sampled bits are collected in a capture register that the host can read.

`busy` covers the whole sequence. `done` is a single-cycle pulse at the end. After `done`, the host may start the sequence again.

Top module: `jtag_entry_seq`

## Requirements
- R1: After reset, `busy`=0, `done`=0, `tck`=0, `tms`=1 and `tdi`=0.
- R2: After `start`, the first RST_PULSES (default 5) TCK rising edges see TMS=1. The next two rising edges see TMS=0 and then TMS=1, which leaves the TAP in Select-DR-Scan.
- R3: The first scan is an instruction scan. It shifts exactly IR_W (4) bits of IR1_VAL (0x2), least significant bit first. TMS is 0 for every shift bit except the last, where it is 1.
- R4: The second scan is a data scan. It shifts DR_W (4) bits of DR_VAL (0x2), least significant bit first, while the instruction register holds 0x2.
- R5: The third scan is an instruction scan that leaves 0xC in the target's instruction register.
- R6: After the first arrival in Select-DR-Scan, the TAP never enters Run-Test/Idle, and every Update state is left with TMS=1. The sequence contains exactly three Update states.
- R7: Each TCK half-period lasts DIV_HALF system clocks. TMS and TDI change only when TCK falls. A complete sequence gives RST_PULSES+2+2*(IR_W+5)+(DR_W+4) rising edges, which is 33 with the defaults.
- R8: TDO is sampled on each rising edge taken in Shift-IR or Shift-DR. Bit i of `cap_data` is the i-th sampled bit counted across the whole sequence. So [3:0] holds the first scan's output, [7:4] the data scan's output and [11:8] the last scan's output, each nibble with its least significant bit shifted out first.
- R9: `busy` rises on the clock after `start` is accepted and falls together with the final TCK falling edge, so it is high for 2*33*DIV_HALF clocks. `done` is high for exactly one clock, in that same cycle, while `busy` is low and `tck` is low.
- R10: A `start` pulse that arrives while `busy` is high has no effect: the step sequence, the pulse count and the duration of `busy` are unchanged.
- R11: A new `start` after `done` repeats the full sequence, and `cap_data` is completely replaced by the new TDO bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches the entry sequence when idle |
| tdo | input | 1 | Test data returned by the target |
| tck | output | 1 | Divided test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-clock pulse at the end of the sequence |
| cap_data | output | 2*IR_W+DR_W | TDO bits sampled during the three shifts |

## Verification
A wrong step counter or a wrong TMS pattern makes the target model end in the wrong TAP state. That state is visible as a wrong final instruction or data value, or as a forbidden entry into Run-Test/Idle, at most one TCK period after the fault. An off-by-one in the shift window shows as a shifted or corrupted nibble in `cap_data` and as a wrong total edge count at `done`. An error in the divider or in edge placement shows within the first TCK period, as a wrong rise-to-rise spacing or as TMS moving while TCK is high.

// File: rtl/jtag_entry_pkg.sv
package jtag_entry_pkg;

  typedef enum logic [3:0] {
    TAP_TLR, TAP_RTI, TAP_SELDR, TAP_CAPDR, TAP_SHDR, TAP_EX1DR, TAP_PAUDR, TAP_EX2DR,
    TAP_UPDR, TAP_SELIR, TAP_CAPIR, TAP_SHIR, TAP_EX1IR, TAP_PAUIR, TAP_EX2IR, TAP_UPIR
  } tap_state_t;

  function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
    unique case (s)
      TAP_TLR:   return m ? TAP_TLR   : TAP_RTI;
      TAP_RTI:   return m ? TAP_SELDR : TAP_RTI;
      TAP_SELDR: return m ? TAP_SELIR : TAP_CAPDR;
      TAP_CAPDR: return m ? TAP_EX1DR : TAP_SHDR;
      TAP_SHDR:  return m ? TAP_EX1DR : TAP_SHDR;
      TAP_EX1DR: return m ? TAP_UPDR  : TAP_PAUDR;
      TAP_PAUDR: return m ? TAP_EX2DR : TAP_PAUDR;
      TAP_EX2DR: return m ? TAP_UPDR  : TAP_SHDR;
      TAP_UPDR:  return m ? TAP_SELDR : TAP_RTI;
      TAP_SELIR: return m ? TAP_TLR   : TAP_CAPIR;
      TAP_CAPIR: return m ? TAP_EX1IR : TAP_SHIR;
      TAP_SHIR:  return m ? TAP_EX1IR : TAP_SHIR;
      TAP_EX1IR: return m ? TAP_UPIR  : TAP_PAUIR;
      TAP_PAUIR: return m ? TAP_EX2IR : TAP_PAUIR;
      TAP_EX2IR: return m ? TAP_UPIR  : TAP_SHIR;
      default:   return m ? TAP_SELDR : TAP_RTI;
    endcase
  endfunction

endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tck,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CNT_W = $clog2(DIV_HALF + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tck_q;
  logic             wrap;

  assign wrap     = run && (cnt_q == CNT_W'(DIV_HALF - 1));
  assign rise_stb = wrap && !tck_q;
  assign fall_stb = wrap && tck_q;
  assign tck      = tck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/jtag_step_gen.sv
module jtag_step_gen #(
  parameter int RST_PULSES = 5,
  parameter int IR_W = 4,
  parameter int DR_W = 4,
  parameter logic [IR_W-1:0] IR1_VAL = IR_W'(2),
  parameter logic [DR_W-1:0] DR_VAL  = DR_W'(2),
  parameter logic [IR_W-1:0] IR2_VAL = IR_W'(12),
  parameter int STEP_W = 6
) (
  input  logic [STEP_W-1:0] idx,
  output logic              tms,
  output logic              tdi
);
  localparam int IR_LEN = IR_W + 5;
  localparam int DR_LEN = DR_W + 4;
  localparam int S_IR1  = RST_PULSES + 2;
  localparam int S_DR   = S_IR1 + IR_LEN;
  localparam int S_IR2  = S_DR + DR_LEN;

  always_comb begin
    int i;
    int off;
    i   = int'(idx);
    off = 0;
    tms = 1'b1;
    tdi = 1'b0;
    if (i == RST_PULSES) begin
      tms = 1'b0;
    end else if (i < S_IR1) begin
      tms = 1'b1;
    end else if (i < S_DR || i >= S_IR2) begin
      // instruction scan: SelIR, CapIR, ShiftIR entry, bits, Update, SelDR
      off = (i < S_DR) ? i - S_IR1 : i - S_IR2;
      tms = !(off == 1 || off == 2);
      for (int b = 0; b < IR_W; b++) begin
        if (off == b + 3) begin
          tms = (b == IR_W - 1);
          tdi = (i < S_DR) ? IR1_VAL[b] : IR2_VAL[b];
        end
      end
    end else begin
      // data scan: CapDR, ShiftDR entry, bits, Update, SelDR
      off = i - S_DR;
      tms = (off >= 2);
      for (int b = 0; b < DR_W; b++) begin
        if (off == b + 2) begin
          tms = (b == DR_W - 1);
          tdi = DR_VAL[b];
        end
      end
    end
  end
endmodule

// File: rtl/jtag_tap_track.sv
module jtag_tap_track
  import jtag_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       adv,
  input  logic       tms,
  output tap_state_t state,
  output logic       shifting
);
  tap_state_t st_q;

  assign state    = st_q;
  assign shifting = (st_q == TAP_SHIR) || (st_q == TAP_SHDR);

  always_ff @(posedge clk) begin
    if (rst || clear) st_q <= TAP_TLR;
    else if (adv)     st_q <= tap_next(st_q, tms);
  end

  // R6: every Update state is left toward Select-DR-Scan
  a_r6_update_exit_high: assert property (@(posedge clk) disable iff (rst)
    adv && (st_q == TAP_UPIR || st_q == TAP_UPDR) |-> tms);
endmodule

// File: rtl/jtag_entry_seq.sv
module jtag_entry_seq
  import jtag_entry_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int RST_PULSES = 5,
  parameter int IR_W = 4,
  parameter int DR_W = 4,
  parameter logic [IR_W-1:0] IR1_VAL = IR_W'(2),
  parameter logic [DR_W-1:0] DR_VAL  = DR_W'(2),
  parameter logic [IR_W-1:0] IR2_VAL = IR_W'(12)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     tdo,
  output logic                     tck,
  output logic                     tms,
  output logic                     tdi,
  output logic                     busy,
  output logic                     done,
  output logic [2*IR_W+DR_W-1:0]   cap_data
);
  localparam int CAP_W   = 2 * IR_W + DR_W;
  localparam int S_IR1   = RST_PULSES + 2;
  localparam int N_STEPS = S_IR1 + 2 * (IR_W + 5) + (DR_W + 4);
  localparam int STEP_W  = $clog2(N_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  logic [STEP_W-1:0] step_q, idx;
  logic              busy_q, done_q, tms_q, tdi_q;
  logic [CAP_W-1:0]  cap_q;
  logic              g_tms, g_tdi, rise_stb, fall_stb, shifting, accept;
  tap_state_t        trk;

  assign accept = start && !busy_q;
  assign idx    = busy_q ? step_q + STEP_W'(1) : '0;

  jtag_tck_gen #(.DIV_HALF(DIV_HALF)) u_tck (
    .clk(clk), .rst(rst), .run(busy_q),
    .tck(tck), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  jtag_step_gen #(
    .RST_PULSES(RST_PULSES), .IR_W(IR_W), .DR_W(DR_W),
    .IR1_VAL(IR1_VAL), .DR_VAL(DR_VAL), .IR2_VAL(IR2_VAL), .STEP_W(STEP_W)
  ) u_step (
    .idx(idx), .tms(g_tms), .tdi(g_tdi)
  );

  jtag_tap_track u_trk (
    .clk(clk), .rst(rst), .clear(accept), .adv(rise_stb), .tms(tms_q),
    .state(trk), .shifting(shifting)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      tms_q  <= 1'b1;
      tdi_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        tms_q  <= g_tms;
        tdi_q  <= g_tdi;
      end else if (busy_q && fall_stb) begin
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= idx;
          tms_q  <= g_tms;
          tdi_q  <= g_tdi;
        end
      end
      if (rise_stb && shifting) cap_q <= {tdo, cap_q[CAP_W-1:1]};
    end
  end

  assign tms      = tms_q;
  assign tdi      = tdi_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign cap_data = cap_q;

  // R6: no Run-Test/Idle once scanning has begun
  a_r6_no_idle_state: assert property (@(posedge clk) disable iff (rst)
    busy_q && (step_q >= STEP_W'(S_IR1)) |-> trk != TAP_RTI);

  // R7: TMS and TDI hold while TCK is high
  a_r7_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    tck |-> $stable(tms_q) && $stable(tdi_q));

  // R9: done ends in Select-DR-Scan with the clock parked low
  a_r9_done_state: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q && !tck && trk == TAP_SELDR);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: start during a run does not restart it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy_q && start && !fall_stb |=> busy_q && $stable(step_q));
endmodule

// File: tb/jtag_entry_seq_tb_top.sv
`timescale 1ns/1ps
module jtag_entry_seq_tb_top;
  localparam int DIV_HALF = 4;
  localparam int N_RISE   = 33;
  localparam int BUSY_CYC = 2 * N_RISE * DIV_HALF;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, tdo = 1'b0;
  logic tck, tms, tdi, busy, done;
  logic [11:0] cap_data;

  always #4 clk = ~clk;

  jtag_entry_seq #(.DIV_HALF(DIV_HALF)) dut_i (
    .clk(clk), .rst(rst), .start(start), .tdo(tdo), .tck(tck), .tms(tms),
    .tdi(tdi), .busy(busy), .done(done), .cap_data(cap_data)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- target TAP model ----------------
  localparam int M_TLR=0, M_RTI=1, M_SELDR=2, M_CAPDR=3, M_SHDR=4, M_EX1DR=5, M_PAUDR=6,
                 M_EX2DR=7, M_UPDR=8, M_SELIR=9, M_CAPIR=10, M_SHIR=11, M_EX1IR=12,
                 M_PAUIR=13, M_EX2IR=14, M_UPIR=15;
  int m_st = M_TLR;
  logic [3:0] ir_sr, dr_sr, ir_reg, dr_reg, ir_at_dr, m_ir_cap, m_dr_cap;
  logic [3:0] ir_hist [2];
  logic [63:0] tms_hist;
  int rise_cnt, n_ir, n_dr, n_upd, rti_bad, upd_bad, sh_ir, sh_dr, period_bad, seen_sel;
  realtime t_last;

  always @(posedge tck) begin
    if (rise_cnt < 64) tms_hist[rise_cnt] = tms;
    rise_cnt++;
    if (t_last > 0 && ($realtime - t_last) != 2.0 * DIV_HALF * 8.0) period_bad++;
    t_last = $realtime;
    if ((m_st == M_UPDR || m_st == M_UPIR) && !tms) upd_bad++;
    case (m_st)
      M_CAPIR: ir_sr = m_ir_cap;
      M_SHIR:  begin ir_sr = {tdi, ir_sr[3:1]}; sh_ir++; end
      M_UPIR:  begin ir_reg = ir_sr; if (n_ir < 2) ir_hist[n_ir] = ir_sr; n_ir++; n_upd++; end
      M_CAPDR: dr_sr = m_dr_cap;
      M_SHDR:  begin dr_sr = {tdi, dr_sr[3:1]}; sh_dr++; end
      M_UPDR:  begin dr_reg = dr_sr; ir_at_dr = ir_reg; n_dr++; n_upd++; end
      default: ;
    endcase
    case (m_st)
      M_TLR:   m_st = tms ? M_TLR   : M_RTI;
      M_RTI:   m_st = tms ? M_SELDR : M_RTI;
      M_SELDR: m_st = tms ? M_SELIR : M_CAPDR;
      M_CAPDR: m_st = tms ? M_EX1DR : M_SHDR;
      M_SHDR:  m_st = tms ? M_EX1DR : M_SHDR;
      M_EX1DR: m_st = tms ? M_UPDR  : M_PAUDR;
      M_PAUDR: m_st = tms ? M_EX2DR : M_PAUDR;
      M_EX2DR: m_st = tms ? M_UPDR  : M_SHDR;
      M_UPDR:  m_st = tms ? M_SELDR : M_RTI;
      M_SELIR: m_st = tms ? M_TLR   : M_CAPIR;
      M_CAPIR: m_st = tms ? M_EX1IR : M_SHIR;
      M_SHIR:  m_st = tms ? M_EX1IR : M_SHIR;
      M_EX1IR: m_st = tms ? M_UPIR  : M_PAUIR;
      M_PAUIR: m_st = tms ? M_EX2IR : M_PAUIR;
      M_EX2IR: m_st = tms ? M_UPIR  : M_SHIR;
      default: m_st = tms ? M_SELDR : M_RTI;
    endcase
    if (seen_sel != 0 && m_st == M_RTI) rti_bad++;
    if (m_st == M_SELDR) seen_sel = 1;
  end

  always @(negedge tck)
    tdo = (m_st == M_SHIR) ? ir_sr[0] : (m_st == M_SHDR) ? dr_sr[0] : 1'b0;

  // ---------------- port monitors (mid-cycle) ----------------
  int busy_cyc, done_cyc, hold_bad, done_bad;
  logic tck_l = 1'b0, tms_l = 1'b1, tdi_l = 1'b0;
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (done) begin done_cyc++; if (busy || tck) done_bad++; end
    if (tck && tck_l && (tms !== tms_l || tdi !== tdi_l)) hold_bad++;
    tck_l = tck; tms_l = tms; tdi_l = tdi;
  end

  task automatic m_clear(input logic [3:0] irc, input logic [3:0] drc);
    m_st = M_TLR; m_ir_cap = irc; m_dr_cap = drc;
    ir_reg = '0; dr_reg = '0; ir_at_dr = '0; ir_hist[0] = '0; ir_hist[1] = '0;
    tms_hist = '0; rise_cnt = 0; n_ir = 0; n_dr = 0; n_upd = 0; rti_bad = 0; upd_bad = 0;
    sh_ir = 0; sh_dr = 0; period_bad = 0; seen_sel = 0; t_last = 0;
    busy_cyc = 0; done_cyc = 0; hold_bad = 0; done_bad = 0;
  endtask

  task automatic run_seq(input logic [3:0] irc, input logic [3:0] drc, input bit poke);
    int n;
    m_clear(irc, drc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 busy after start", 32'(busy), 32'd1);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk); n++;
      if (poke && n == 100) start = 1'b1;
      if (poke && n == 101) start = 1'b0;
    end
    chk("R9 done seen", 32'(done), 32'd1);
    chk("R9 tck low at done", 32'(tck), 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done_cyc), 32'd1);
    chk("R9 done with busy low", 32'(done_bad), 32'd0);
    chk("R9 R10 busy length", 32'(busy_cyc), 32'(BUSY_CYC));
    chk("R7 R10 rising edge count", 32'(rise_cnt), 32'(N_RISE));
    chk("R5 final IR", 32'(ir_reg), 32'hC);
    chk("R8 R11 capture", 32'(cap_data), {20'd0, irc, drc, irc});
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 tck", 32'(tck), 32'd0);
    chk("R1 tms", 32'(tms), 32'd1);
    chk("R1 tdi", 32'(tdi), 32'd0);
  endtask

  task automatic t_main();
    run_seq(4'h5, 4'h9, 1'b0);
    chk("R2 reset and walk TMS", 32'(tms_hist[6:0]), 32'h5F);
    chk("R3 first IR value", 32'(ir_hist[0]), 32'h2);
    chk("R3 IR shift count", 32'(sh_ir), 32'd8);
    chk("R3 first IR shift TMS", 32'(tms_hist[13:10]), 32'h8);
    chk("R4 DR value", 32'(dr_reg), 32'h2);
    chk("R4 IR during DR", 32'(ir_at_dr), 32'h2);
    chk("R4 DR shift count", 32'(sh_dr), 32'd4);
    chk("R6 no Run-Test/Idle", 32'(rti_bad), 32'd0);
    chk("R6 update exits high", 32'(upd_bad), 32'd0);
    chk("R6 update count", 32'(n_upd), 32'd3);
    chk("R7 period", 32'(period_bad), 32'd0);
    chk("R7 TMS/TDI hold while high", 32'(hold_bad), 32'd0);
  endtask

  task automatic t_ignore();
    run_seq(4'h5, 4'h9, 1'b1);
    chk("R10 IR scans intact", 32'(n_ir), 32'd2);
    chk("R10 no Run-Test/Idle", 32'(rti_bad), 32'd0);
  endtask

  task automatic t_rerun();
    run_seq(4'h6, 4'hE, 1'b0);
    chk("R11 first IR on rerun", 32'(ir_hist[0]), 32'h2);
    chk("R11 DR on rerun", 32'(dr_reg), 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_main();
    repeat (5) @(negedge clk);
    t_ignore();
    repeat (5) @(negedge clk);
    t_rerun();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule